// File: doc/BRIEF.md
# Zero-Padding Feature Row Buffer

This block sits between a byte-wide feature-map loader and a four-row multiply-accumulate array. Bytes arrive one at a time, each tagged with the array row it belongs to, and are appended to that row's own storage in arrival order. A later channel segment written to a row therefore lands directly behind the earlier segment in the same stream, which is how channels beyond the array's width are joined onto earlier ones (channel 17 after channel 1, for instance).

A start pulse, together with a layer mode and a per-row sample count, sets off an emission pass. On every cycle of the pass, one byte per row leaves the controller. It is either a stored sample or an inserted zero, with the zero pattern chosen by the layer mode. Four per-row packers gather these bytes into 32-bit words for the array. The storage has two banks. While one bank is being emitted, the loader can already fill the other one.

Top module: `zpad_row_buffer`

## Requirements
- R1: After reset, `busy` is 0, every `row_valid` bit is 0 and `row_data` is all zeros.
- R2: With `cfg_mode` = 2'b00 (convolution), each row emits its first `cfg_len` stored bytes followed by exactly 3 zero bytes.
- R3: With `cfg_mode` = 2'b01 (deconvolution), each row emits 3 zero bytes, then the `cfg_len` samples with one zero byte between each adjacent pair, then 3 zero bytes.
- R4: With `cfg_mode` = 2'b10 (fully connected; 2'b11 behaves the same), each row emits exactly its first `cfg_len` stored bytes and no zeros.
- R5: Each row packs its emitted bytes four at a time, with the earliest byte in bits [7:0] and the fourth in bits [31:24]. A word is shown for one cycle with its valid bit high. If the stream ends on a partial word, that word is emitted with zero bytes in its unfilled upper positions, and it is also marked valid.
- R6: Every row has its own storage, written through `wr_row` (0..3). All four rows emit in lockstep, so their `row_valid` bits are always either all 0 or all 1.
- R7: Bytes written to one row are emitted in write order, so a second channel segment written after a first one follows it directly in the same stream.
- R8: Bytes written while a pass is running go to the other bank. They do not change the words being emitted, and they are the data emitted by the next accepted start.
- R9: A start is accepted only when `busy` is 0; a start during a pass is ignored and causes no extra words. `busy` rises only in the cycle after an accepted start.
- R10: Each row's 32-bit data output is zero in any cycle in which its valid bit is low.
- R11: Once a row has received 32 bytes since the last accepted start, further writes to that row are ignored and do not overwrite any stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one feature byte this cycle |
| wr_row | input | 2 | Target row of the write |
| wr_data | input | 8 | Feature byte |
| start | input | 1 | Begin an emission pass of the filled bank |
| cfg_mode | input | 2 | Layer mode: 00 convolution, 01 deconvolution, 10/11 fully connected |
| cfg_len | input | 6 | Samples per row for the pass (1..32) |
| busy | output | 1 | Emission pass in progress |
| row_valid | output | 4 | Per-row word valid |
| row_data | output | 128 | Per-row packed words, row r in bits [32r+31:32r] |

## Verification
The assertions check, on every cycle, the properties that hold at all times: the rows stay in lockstep, the data outputs are zero whenever their valid bits are low, no word appears while the block has been idle for more than a cycle, and `busy` never rises without a start. The byte content of the streams can only be shown by the bench scenarios, which cover each padding pattern, the zero-filled partial final word, channel concatenation, writes to the other bank during a pass, an ignored mid-pass start and row overflow. In each case the bench compares every collected word with a stream built from the bytes it wrote.

// File: rtl/zpad_pkg.sv
// Shared types for the zero-padding row buffer.
// Assumes: mode codes are fixed by the port contract; 2'b11 acts as fully connected.
package zpad_pkg;

    typedef enum logic [1:0] {
        MODE_CONV   = 2'b00,
        MODE_DECONV = 2'b01,
        MODE_FC     = 2'b10,
        MODE_FC_ALT = 2'b11
    } layer_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PAD_HEAD,
        ST_EMIT_DATA,
        ST_PAD_TAIL
    } pad_state_t;

endpackage

// File: rtl/zpad_row_store.sv
// Two-bank byte storage, one region per array row.
// Writes append at a per-row pointer in the write bank. A swap makes the write
// bank the read bank and clears the pointers. Reads are asynchronous, by address.
// Assumes: swap is asserted only when the reader is idle.
module zpad_row_store #(
    parameter int ROWS  = 4,
    parameter int DEPTH = 32,
    parameter int RW    = $clog2(ROWS),
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [RW-1:0]          wr_row,
    input  logic [7:0]             wr_data,
    input  logic                   swap,
    input  logic [AW-1:0]          rd_addr,
    output logic [ROWS-1:0][7:0]   rd_byte
);
    localparam int PW      = $clog2(DEPTH + 1);
    localparam int ENTRIES = 2 * ROWS * DEPTH;

    logic [7:0]          mem [ENTRIES];
    logic [ROWS-1:0][PW-1:0] wr_ptr;
    logic                wr_bank;
    logic                rd_bank;
    logic                wr_ok;

    assign wr_ok = wr_en && (wr_ptr[wr_row] < PW'(DEPTH));

    // Bank selection and per-row fill pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank <= 1'b0;
            rd_bank <= 1'b1;
            wr_ptr  <= '0;
        end else if (swap) begin
            rd_bank <= wr_bank;
            wr_bank <= ~wr_bank;
            wr_ptr  <= '0;
        end else if (wr_ok) begin
            wr_ptr[wr_row] <= wr_ptr[wr_row] + PW'(1);
        end
    end

    // Byte array write port.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[(int'(wr_bank) * ROWS + int'(wr_row)) * DEPTH + int'(wr_ptr[wr_row])] <= wr_data;
        end
    end

    // One asynchronous read per row at the shared address.
    for (genvar r = 0; r < ROWS; r++) begin : g_rd
        assign rd_byte[r] = mem[(int'(rd_bank) * ROWS + r) * DEPTH + int'(rd_addr)];
    end

endmodule

// File: rtl/zpad_ctrl.sv
// Padding sequencer. For each pass it produces one byte slot per cycle, marked
// as a sample (read at rd_addr) or an inserted zero, and it flags the last slot.
// Assumes: cfg_len is 1..DEPTH; a length of 0 is treated as 1.
module zpad_ctrl
    import zpad_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int KERNEL = 4,
    parameter int AW     = $clog2(DEPTH),
    parameter int LW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cfg_mode,
    input  logic [LW-1:0] cfg_len,
    output logic          accept,
    output logic          busy,
    output logic [AW-1:0] rd_addr,
    output logic          slot_valid,
    output logic          slot_zero,
    output logic          slot_last
);
    localparam int PAD = KERNEL - 1;
    localparam int CW  = (PAD > 1) ? $clog2(PAD) : 1;

    pad_state_t    state;
    layer_mode_t   mode_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] samp_idx;
    logic [CW-1:0] cnt;
    logic          zphase;
    logic          last_samp;
    logic          is_fc;
    logic          is_deconv;

    assign accept    = start && (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign rd_addr   = samp_idx[AW-1:0];
    assign last_samp = (samp_idx == len_q - LW'(1));
    assign is_fc     = (mode_q == MODE_FC) || (mode_q == MODE_FC_ALT);
    assign is_deconv = (mode_q == MODE_DECONV);

    // Slot type for the current state.
    always_comb begin
        slot_valid = 1'b0;
        slot_zero  = 1'b0;
        slot_last  = 1'b0;
        unique case (state)
            ST_PAD_HEAD: begin
                slot_valid = 1'b1;
                slot_zero  = 1'b1;
            end
            ST_EMIT_DATA: begin
                slot_valid = 1'b1;
                slot_zero  = zphase;
                slot_last  = !zphase && last_samp && is_fc;
            end
            ST_PAD_TAIL: begin
                slot_valid = 1'b1;
                slot_zero  = 1'b1;
                slot_last  = (cnt == CW'(PAD - 1));
            end
            default: ;
        endcase
    end

    // State, configuration latch and position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mode_q   <= MODE_CONV;
            len_q    <= LW'(1);
            samp_idx <= '0;
            cnt      <= '0;
            zphase   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    mode_q <= layer_mode_t'(cfg_mode);
                    len_q  <= (cfg_len == '0) ? LW'(1) : cfg_len;
                    state  <= ST_LOAD;
                end
                ST_LOAD: begin
                    samp_idx <= '0;
                    cnt      <= '0;
                    zphase   <= 1'b0;
                    state    <= is_deconv ? ST_PAD_HEAD : ST_EMIT_DATA;
                end
                ST_PAD_HEAD: begin
                    cnt <= cnt + CW'(1);
                    if (cnt == CW'(PAD - 1)) begin
                        cnt   <= '0;
                        state <= ST_EMIT_DATA;
                    end
                end
                ST_EMIT_DATA: begin
                    if (zphase) begin
                        zphase   <= 1'b0;
                        samp_idx <= samp_idx + LW'(1);
                    end else if (last_samp) begin
                        cnt   <= '0;
                        state <= is_fc ? ST_IDLE : ST_PAD_TAIL;
                    end else if (is_deconv) begin
                        zphase <= 1'b1;
                    end else begin
                        samp_idx <= samp_idx + LW'(1);
                    end
                end
                ST_PAD_TAIL: begin
                    cnt <= cnt + CW'(1);
                    if (cnt == CW'(PAD - 1)) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/zpad_deser.sv
// Per-row packer: gathers byte slots into a 32-bit word, earliest byte lowest.
// It emits a registered word after the fourth byte, or after the last byte of
// a pass with the unfilled upper bytes left at zero. The data is zero when not valid.
// Assumes: slot_last is asserted together with slot_valid.
module zpad_deser #(
    parameter int BYTES = 4,
    parameter int WW    = 8 * BYTES,
    parameter int IW    = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_byte,
    input  logic          in_last,
    output logic          out_valid,
    output logic [WW-1:0] out_data
);
    logic [WW-1:0] acc;
    logic [IW-1:0] idx;
    logic [WW-1:0] merged;

    // Current byte placed into the partial word.
    assign merged = acc | (WW'(in_byte) << (8 * int'(idx)));

    // Byte gathering and word output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            idx       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            out_data  <= '0;
            if (in_valid) begin
                if ((idx == IW'(BYTES - 1)) || in_last) begin
                    out_valid <= 1'b1;
                    out_data  <= merged;
                    acc       <= '0;
                    idx       <= '0;
                end else begin
                    acc <= merged;
                    idx <= idx + IW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/zpad_row_buffer.sv
// Top level: two-bank row storage, padding sequencer and one packer per row.
// Assumes: all rows hold at least cfg_len bytes when a pass starts.
module zpad_row_buffer #(
    parameter int ROWS   = 4,
    parameter int DEPTH  = 32,
    parameter int KERNEL = 4,
    parameter int RW     = $clog2(ROWS),
    parameter int LW     = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RW-1:0]      wr_row,
    input  logic [7:0]         wr_data,
    input  logic               start,
    input  logic [1:0]         cfg_mode,
    input  logic [LW-1:0]      cfg_len,
    output logic               busy,
    output logic [ROWS-1:0]    row_valid,
    output logic [ROWS*32-1:0] row_data
);
    localparam int AW = $clog2(DEPTH);

    logic                 accept;
    logic [AW-1:0]        rd_addr;
    logic [ROWS-1:0][7:0] rd_byte;
    logic                 slot_valid;
    logic                 slot_zero;
    logic                 slot_last;

    zpad_row_store #(.ROWS(ROWS), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .swap    (accept),
        .rd_addr (rd_addr),
        .rd_byte (rd_byte)
    );

    zpad_ctrl #(.DEPTH(DEPTH), .KERNEL(KERNEL)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_mode   (cfg_mode),
        .cfg_len    (cfg_len),
        .accept     (accept),
        .busy       (busy),
        .rd_addr    (rd_addr),
        .slot_valid (slot_valid),
        .slot_zero  (slot_zero),
        .slot_last  (slot_last)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [7:0] row_byte;
        assign row_byte = slot_zero ? 8'h00 : rd_byte[r];

        zpad_deser #(.BYTES(4)) u_deser (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (slot_valid),
            .in_byte   (row_byte),
            .in_last   (slot_last),
            .out_valid (row_valid[r]),
            .out_data  (row_data[r*32 +: 32])
        );
    end

endmodule

// File: rtl/zpad_row_buffer_chk.sv
// Checker for the row buffer's port-level invariants; bound to every instance.
module zpad_row_buffer_chk #(
    parameter int ROWS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic [ROWS-1:0]    row_valid,
    input logic [ROWS*32-1:0] row_data
);
    // R6: all rows present their words in the same cycle.
    assert_rows_lockstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid == '0) || (row_valid == '1));

    // R9: busy rises only after a start was presented.
    assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R9: no words once the block has been idle for more than one cycle.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> (row_valid == '0));

    for (genvar r = 0; r < ROWS; r++) begin : g_chk
        // R10: the data of each row is zero while its valid bit is low.
        assert_data_zero_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !row_valid[r] |-> (row_data[r*32 +: 32] == 32'h0));
    end
endmodule

bind zpad_row_buffer zpad_row_buffer_chk #(.ROWS(ROWS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .row_valid (row_valid),
    .row_data  (row_data)
);

// File: tb/zpad_row_buffer_tb.sv
// Directed bench for the zero-padding row buffer.
module zpad_row_buffer_tb;
    localparam int ROWS  = 4;
    localparam int DEPTH = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [1:0]         wr_row = '0;
    logic [7:0]         wr_data = '0;
    logic               start = 1'b0;
    logic [1:0]         cfg_mode = '0;
    logic [5:0]         cfg_len = '0;
    logic               busy;
    logic [ROWS-1:0]    row_valid;
    logic [ROWS*32-1:0] row_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0]  wq  [ROWS][$];
    logic [7:0]  src [ROWS][$];
    logic [31:0] got [ROWS][$];

    zpad_row_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
        .wr_data(wr_data), .start(start), .cfg_mode(cfg_mode),
        .cfg_len(cfg_len), .busy(busy), .row_valid(row_valid),
        .row_data(row_data)
    );

    always #5 clk = ~clk;

    // Monitor: gather words and check row lockstep away from the edge.
    always @(negedge clk) begin
        if (rst_n && row_valid != '0) begin
            checks++;
            if (row_valid != '1) begin
                fails++;
                $display("FAIL R6 lockstep: row_valid=%b expected=%b", row_valid, 4'hF);
            end
            for (int r = 0; r < ROWS; r++)
                if (row_valid[r]) got[r].push_back(row_data[r*32 +: 32]);
        end
    end

    task automatic wr_byte(input int row, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 2'(row); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (wq[row].size() < DEPTH) wq[row].push_back(d);
    endtask

    task automatic fill_rows(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++)
            for (int r = 0; r < ROWS; r++)
                wr_byte(r, base + 8'(16 * r) + 8'(i) + 8'd1);
    endtask

    task automatic pulse_start(input logic [1:0] mode, input int len);
        @(negedge clk);
        start = 1'b1; cfg_mode = mode; cfg_len = 6'(len);
        @(negedge clk);
        start = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            src[r] = wq[r];
            wq[r].delete();
            got[r].delete();
        end
    endtask

    task automatic wait_done();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic compare(input logic [1:0] mode, input int len, input string req);
        for (int r = 0; r < ROWS; r++) begin
            logic [7:0]  s [$];
            logic [31:0] w [$];
            if (mode == 2'b01) begin
                for (int k = 0; k < 3; k++) s.push_back(8'h00);
                for (int i = 0; i < len; i++) begin
                    s.push_back(src[r][i]);
                    if (i != len - 1) s.push_back(8'h00);
                end
                for (int k = 0; k < 3; k++) s.push_back(8'h00);
            end else begin
                for (int i = 0; i < len; i++) s.push_back(src[r][i]);
                if (mode == 2'b00)
                    for (int k = 0; k < 3; k++) s.push_back(8'h00);
            end
            for (int i = 0; i < s.size(); i += 4) begin
                logic [31:0] word = '0;
                for (int b = 0; b < 4; b++)
                    if (i + b < s.size()) word[8*b +: 8] = s[i + b];
                w.push_back(word);
            end
            checks++;
            if (got[r].size() != w.size()) begin
                fails++;
                $display("FAIL %s row %0d word count: actual=%0d expected=%0d",
                         req, r, got[r].size(), w.size());
            end else begin
                for (int i = 0; i < w.size(); i++) begin
                    checks++;
                    if (got[r][i] !== w[i]) begin
                        fails++;
                        $display("FAIL %s row %0d word %0d: actual=%h expected=%h",
                                 req, r, i, got[r][i], w[i]);
                    end
                end
            end
        end
    endtask

    task automatic check_idle(input string req);
        checks++;
        if (busy !== 1'b0 || row_valid !== '0 || row_data !== '0) begin
            fails++;
            $display("FAIL %s idle outputs: actual busy=%b valid=%b data=%h expected 0/0/0",
                     req, busy, row_valid, row_data);
        end
    endtask

    task automatic t_reset();
        check_idle("R1");
    endtask

    task automatic t_run(input logic [1:0] mode, input int len, input logic [7:0] base,
                         input string req);
        fill_rows(len, base);
        pulse_start(mode, len);
        wait_done();
        compare(mode, len, req);
        check_idle("R10");
    endtask

    // R7: two channel segments in one row stream, second follows first.
    task automatic t_concat();
        for (int r = 0; r < ROWS; r++)
            for (int i = 0; i < 4; i++) wr_byte(r, 8'hA0 + 8'(i) + 8'(r * 4));
        for (int r = 0; r < ROWS; r++)
            for (int i = 0; i < 4; i++) wr_byte(r, 8'hC0 + 8'(i) + 8'(r * 4));
        pulse_start(2'b10, 8);
        wait_done();
        compare(2'b10, 8, "R7");
    endtask

    // R8 and R9: writes and a second start during a pass.
    task automatic t_overlap();
        fill_rows(6, 8'h40);
        pulse_start(2'b01, 6);
        fill_rows(2, 8'h70);
        @(negedge clk); start = 1'b1; cfg_mode = 2'b10; cfg_len = 6'd2;
        @(negedge clk); start = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        compare(2'b01, 6, "R8/R9");
        pulse_start(2'b10, 2);
        wait_done();
        compare(2'b10, 2, "R8");
    endtask

    // R11: writes beyond capacity are dropped.
    task automatic t_overflow();
        fill_rows(DEPTH, 8'h00);
        for (int r = 0; r < ROWS; r++) begin
            wr_byte(r, 8'hEE);
            wr_byte(r, 8'hDD);
        end
        pulse_start(2'b10, DEPTH);
        wait_done();
        compare(2'b10, DEPTH, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run(2'b00, 6, 8'h00, "R2");
        t_run(2'b00, 5, 8'h80, "R2/R5");
        t_run(2'b01, 5, 8'h10, "R3/R5");
        t_run(2'b01, 1, 8'h30, "R3");
        t_run(2'b10, 8, 8'h50, "R4");
        t_run(2'b10, 5, 8'h60, "R4/R5");
        t_concat();
        t_overlap();
        t_overflow();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule